// File: doc/BRIEF.md
# Descriptor Ring Pointer Queue

This block keeps the bookkeeping for one circular descriptor ring that software and a DMA engine share. It stores the ring's base address, its depth, a write pointer and a read pointer, and from those it derives an occupancy level together with empty, full, almost-empty and almost-full indications. Software reaches it through a small word-addressed register port. The DMA side has a one-bit advance request and receives the byte address of the descriptor it is currently working on.

The parameter `SW_PRODUCER` sets the direction of the ring. With the value 1 it is a fill ring: software posts descriptors by moving the write pointer and the engine consumes them by moving the read pointer. The reported level is then the number of valid descriptors. With the value 0 it is a completion ring: the engine moves the write pointer and software retires entries with the read pointer. The reported level is then the number of free descriptors. Pointers are byte offsets with a 32-byte descriptor stride. Depth is programmed as the descriptor count shifted left by three. Base, depth and the engine-owned pointer can only be changed while their bit in the enable word is set, which lets software initialise a ring without racing the engine.

Top module: `dring_queue`

## Requirements
- R1: After reset the enable word (word 0) reads 0, the base address (word 1) reads 0, the depth (word 2) reads MAX_DEPTH<<3, both pointers (write pointer word 3, read pointer word 4) read 0, the low threshold (word 6) reads 0 and the high threshold (word 7) reads MAX_DEPTH-1. The register word is selected by reg_addr[4:2].
- R2: A write to the base address takes effect only while enable bit 2 is set. Otherwise it is ignored.
- R3: A write to the depth register is accepted only while enable bit 1 is set and only when value>>3 is a power of two from 2 to MAX_DEPTH with no bits above it. An accepted write sets the depth and clears both pointers, taking precedence over a same-cycle advance. Any other depth write is ignored.
- R4: The software-owned pointer (write pointer when SW_PRODUCER=1, read pointer otherwise) is written on every write to its word, to index (value>>5) modulo depth. Both pointers read back as index*32.
- R5: A software write to the engine-owned pointer takes effect only while enable bit 0 is set, using the same conversion as R4. Otherwise it is ignored.
- R6: An accepted advance moves the engine-owned pointer by one descriptor modulo depth in the following cycle. hw_entry_addr always equals base + engine index * 32, modulo 2^32.
- R7: hw_adv_ok is high exactly when hw_adv is high and the ring is not empty (SW_PRODUCER=1) or not full (SW_PRODUCER=0). A refused advance leaves the pointer unchanged.
- R8: With used = (write index - read index) mod depth, q_level (and word 5) equals used when SW_PRODUCER=1 and depth-1-used when SW_PRODUCER=0. Word 5 ignores writes.
- R9: q_empty is high when used is 0, and q_full is high when used is depth-1.
- R10: q_al_empty is high when q_level is at or below the low threshold. q_al_full is high when q_level is at or above the high threshold. Both thresholds are written freely from value[DEP_W-1:0].
- R11: A software pointer write and an accepted advance in the same cycle both take effect. When software presets the engine-owned pointer in the cycle of an advance, the preset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register word; bits 4:2 select it |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| hw_adv | input | 1 | Engine request to advance its pointer |
| hw_adv_ok | output | 1 | Advance accepted this cycle |
| hw_entry_addr | output | 32 | Byte address of the descriptor at the engine pointer |
| q_level | output | $clog2(MAX_DEPTH)+1 | Valid count (fill ring) or free count (completion ring) |
| q_empty | output | 1 | No descriptor in the ring |
| q_full | output | 1 | Ring holds depth-1 descriptors |
| q_al_empty | output | 1 | Level at or below the low threshold |
| q_al_full | output | 1 | Level at or above the high threshold |

## Verification
The engine advance and a software register write can land in the same clock. These writes may move the software pointer, preset the engine pointer, or resize the ring and so clear both pointers. The bench drives one stimulus stream into a fill-type and a completion-type instance and holds hw_adv high at random while it writes pointers, enable words and depths at random. A behavioural model applies the R3 and R11 precedence rules and judges every output on every cycle. A directed step presets the engine pointer under a live advance and expects the preset value to read back.

// File: rtl/dring_pkg.sv
package dring_pkg;

    // Register word selected by reg_addr[4:2]
    typedef enum logic [2:0] {
        RG_ENABLE = 3'd0,
        RG_BASE   = 3'd1,
        RG_SIZE   = 3'd2,
        RG_WPTR   = 3'd3,
        RG_RPTR   = 3'd4,
        RG_LEVEL  = 3'd5,
        RG_LOTH   = 3'd6,
        RG_HITH   = 3'd7
    } dring_reg_e;

    // Bits of the enable word
    localparam int EN_BASE_BIT  = 2;
    localparam int EN_SIZE_BIT  = 1;
    localparam int EN_HWPTR_BIT = 0;

    // Pointer byte offset = index << DESC_SHIFT (32-byte stride)
    localparam int DESC_SHIFT = 5;
    // Depth register = descriptor count << SIZE_SHIFT
    localparam int SIZE_SHIFT = 3;

endpackage

// File: rtl/dring_cfg.sv
module dring_cfg
    import dring_pkg::*;
#(
    parameter int MAX_DEPTH = 1024,
    localparam int DEP_W = $clog2(MAX_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  dring_reg_e       wr_sel,
    input  logic [31:0]      wdata,
    output logic [2:0]       en_word,
    output logic [31:0]      base,
    output logic [DEP_W-1:0] depth,
    output logic [DEP_W-1:0] lo_th,
    output logic [DEP_W-1:0] hi_th,
    output logic             size_load
);

    typedef struct packed {
        logic [2:0]       en;
        logic [31:0]      base;
        logic [DEP_W-1:0] depth;
        logic [DEP_W-1:0] lo;
        logic [DEP_W-1:0] hi;
    } cfg_s;

    cfg_s st_d, st_q;

    logic [DEP_W-1:0] cand;
    logic             cand_legal;
    logic             upper_clear;

    always_comb begin
        st_d        = st_q;
        cand        = wdata[SIZE_SHIFT +: DEP_W];
        upper_clear = (wdata >> (SIZE_SHIFT + DEP_W)) == 32'd0;
        cand_legal  = upper_clear
                      && (cand >= DEP_W'(2))
                      && (cand <= DEP_W'(MAX_DEPTH))
                      && ((cand & (cand - DEP_W'(1))) == '0);
        size_load   = wr_en && (wr_sel == RG_SIZE)
                      && st_q.en[EN_SIZE_BIT] && cand_legal;
        if (wr_en) begin
            case (wr_sel)
                RG_ENABLE: st_d.en = wdata[2:0];
                RG_BASE:   if (st_q.en[EN_BASE_BIT]) st_d.base = wdata;
                RG_SIZE:   if (size_load) st_d.depth = cand;
                RG_LOTH:   st_d.lo = wdata[DEP_W-1:0];
                RG_HITH:   st_d.hi = wdata[DEP_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= '0;
            st_q.base  <= '0;
            st_q.depth <= DEP_W'(MAX_DEPTH);
            st_q.lo    <= '0;
            st_q.hi    <= DEP_W'(MAX_DEPTH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign en_word = st_q.en;
    assign base    = st_q.base;
    assign depth   = st_q.depth;
    assign lo_th   = st_q.lo;
    assign hi_th   = st_q.hi;

    // R2: base write with its enable bit clear leaves the base alone
    a_r2_base_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == RG_BASE && !st_q.en[EN_BASE_BIT]) |=> $stable(base));

    // R3: depth write with its enable bit clear leaves the depth alone
    a_r3_size_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == RG_SIZE && !st_q.en[EN_SIZE_BIT]) |=> $stable(depth));

    // R3: depth is always a legal power of two
    a_r3_depth_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(depth) == 1) && (depth >= DEP_W'(2)));

endmodule

// File: rtl/dring_ptrs.sv
module dring_ptrs #(
    parameter int MAX_DEPTH   = 1024,
    parameter bit SW_PRODUCER = 1'b1,
    localparam int IDX_W = $clog2(MAX_DEPTH),
    localparam int DEP_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEP_W-1:0] depth,
    input  logic             clear,
    input  logic             sw_wr,
    input  logic             hw_preset,
    input  logic [IDX_W-1:0] ptr_in,
    input  logic             hw_step,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] hw_idx
);

    typedef struct packed {
        logic [IDX_W-1:0] sw;
        logic [IDX_W-1:0] hw;
    } ptr_s;

    ptr_s p_d, p_q;

    logic [DEP_W-1:0] depth_m1;
    logic [IDX_W-1:0] mask;

    always_comb begin
        depth_m1 = depth - DEP_W'(1);
        mask     = depth_m1[IDX_W-1:0];
        p_d      = p_q;
        if (clear) begin
            p_d.sw = '0;
            p_d.hw = '0;
        end else begin
            if (sw_wr) begin
                p_d.sw = ptr_in & mask;
            end
            if (hw_preset) begin
                p_d.hw = ptr_in & mask;
            end else if (hw_step) begin
                p_d.hw = (p_q.hw + IDX_W'(1)) & mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    generate
        if (SW_PRODUCER) begin : g_fill
            assign wr_idx = p_q.sw;
            assign rd_idx = p_q.hw;
        end else begin : g_done
            assign wr_idx = p_q.hw;
            assign rd_idx = p_q.sw;
        end
    endgenerate

    assign hw_idx = p_q.hw;

    // R4: software pointer write lands modulo depth
    a_r4_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !clear) |=> (p_q.sw == ($past(ptr_in) & $past(mask))));

    // R6: an accepted advance moves the engine pointer by one, wrapping
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_step && !hw_preset && !clear) |=> (hw_idx == (($past(hw_idx) + IDX_W'(1)) & $past(mask))));

    // R3: a resize clears both pointers
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (wr_idx == '0 && rd_idx == '0));

endmodule

// File: rtl/dring_level.sv
module dring_level #(
    parameter int MAX_DEPTH   = 1024,
    parameter bit SW_PRODUCER = 1'b1,
    localparam int IDX_W = $clog2(MAX_DEPTH),
    localparam int DEP_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [DEP_W-1:0] depth,
    input  logic [DEP_W-1:0] lo_th,
    input  logic [DEP_W-1:0] hi_th,
    output logic [DEP_W-1:0] level,
    output logic             empty,
    output logic             full,
    output logic             al_empty,
    output logic             al_full
);

    logic [DEP_W-1:0] depth_m1;
    logic [IDX_W-1:0] diff;
    logic [DEP_W-1:0] used;

    always_comb begin
        depth_m1 = depth - DEP_W'(1);
        diff     = (wr_idx - rd_idx) & depth_m1[IDX_W-1:0];
        used     = DEP_W'(diff);
        empty    = (used == '0);
        full     = (used == depth_m1);
    end

    generate
        if (SW_PRODUCER) begin : g_valid
            assign level = used;
        end else begin : g_free
            assign level = depth_m1 - used;
        end
    endgenerate

    assign al_empty = (level <= lo_th);
    assign al_full  = (level >= hi_th);

endmodule

// File: rtl/dring_queue.sv
module dring_queue
    import dring_pkg::*;
#(
    parameter int MAX_DEPTH   = 1024,
    parameter bit SW_PRODUCER = 1'b1,
    localparam int IDX_W = $clog2(MAX_DEPTH),
    localparam int DEP_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [4:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             hw_adv,
    output logic             hw_adv_ok,
    output logic [31:0]      hw_entry_addr,
    output logic [DEP_W-1:0] q_level,
    output logic             q_empty,
    output logic             q_full,
    output logic             q_al_empty,
    output logic             q_al_full
);

    localparam dring_reg_e SW_SEL = SW_PRODUCER ? RG_WPTR : RG_RPTR;
    localparam dring_reg_e HW_SEL = SW_PRODUCER ? RG_RPTR : RG_WPTR;

    dring_reg_e       sel;
    logic [2:0]       en_word;
    logic [31:0]      base;
    logic [DEP_W-1:0] depth;
    logic [DEP_W-1:0] lo_th;
    logic [DEP_W-1:0] hi_th;
    logic             size_load;
    logic             sw_wr;
    logic             hw_preset;
    logic             blocked;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] hw_idx;
    logic             unused_addr_lsb;

    assign sel             = dring_reg_e'(reg_addr[4:2]);
    assign unused_addr_lsb = ^reg_addr[1:0];
    assign sw_wr           = reg_wr && (sel == SW_SEL);
    assign hw_preset       = reg_wr && (sel == HW_SEL) && en_word[EN_HWPTR_BIT];
    assign blocked         = SW_PRODUCER ? q_empty : q_full;
    assign hw_adv_ok       = hw_adv && !blocked;

    dring_cfg #(.MAX_DEPTH(MAX_DEPTH)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_sel    (sel),
        .wdata     (reg_wdata),
        .en_word   (en_word),
        .base      (base),
        .depth     (depth),
        .lo_th     (lo_th),
        .hi_th     (hi_th),
        .size_load (size_load)
    );

    dring_ptrs #(.MAX_DEPTH(MAX_DEPTH), .SW_PRODUCER(SW_PRODUCER)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .depth     (depth),
        .clear     (size_load),
        .sw_wr     (sw_wr),
        .hw_preset (hw_preset),
        .ptr_in    (reg_wdata[DESC_SHIFT +: IDX_W]),
        .hw_step   (hw_adv_ok),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .hw_idx    (hw_idx)
    );

    dring_level #(.MAX_DEPTH(MAX_DEPTH), .SW_PRODUCER(SW_PRODUCER)) u_level (
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .depth    (depth),
        .lo_th    (lo_th),
        .hi_th    (hi_th),
        .level    (q_level),
        .empty    (q_empty),
        .full     (q_full),
        .al_empty (q_al_empty),
        .al_full  (q_al_full)
    );

    assign hw_entry_addr = base + (32'(hw_idx) << DESC_SHIFT);

    always_comb begin
        case (sel)
            RG_ENABLE: reg_rdata = {29'd0, en_word};
            RG_BASE:   reg_rdata = base;
            RG_SIZE:   reg_rdata = 32'(depth) << SIZE_SHIFT;
            RG_WPTR:   reg_rdata = 32'(wr_idx) << DESC_SHIFT;
            RG_RPTR:   reg_rdata = 32'(rd_idx) << DESC_SHIFT;
            RG_LEVEL:  reg_rdata = 32'(q_level);
            RG_LOTH:   reg_rdata = 32'(lo_th);
            RG_HITH:   reg_rdata = 32'(hi_th);
            default:   reg_rdata = 32'd0;
        endcase
    end

    // R7: a refused advance leaves the engine pointer where it was
    a_r7_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_adv && blocked && !hw_preset && !size_load) |=> $stable(hw_idx));

    // R9: empty and full never coincide (depth is at least two)
    a_r9_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_empty && q_full));

    // R8: reported level never exceeds the ring capacity
    a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= (depth - DEP_W'(1)));

    // R11: a preset of the engine pointer overrides a same-cycle advance
    a_r11_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_preset && !size_load) |=> (hw_idx == ($past(reg_wdata[DESC_SHIFT +: IDX_W]) & $past(depth_m1_idx()))));

    function automatic logic [IDX_W-1:0] depth_m1_idx();
        logic [DEP_W-1:0] t;
        t = depth - DEP_W'(1);
        return t[IDX_W-1:0];
    endfunction

endmodule

// File: tb/dring_queue_bench.sv
module dring_queue_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAXD       = 1024;
    localparam int DW         = $clog2(MAXD) + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        hw_adv = 1'b0;

    logic [31:0] rdata [2];
    logic        ok    [2];
    logic [31:0] entry [2];
    logic [DW-1:0] lvl [2];
    logic        emp [2];
    logic        ful [2];
    logic        ale [2];
    logic        alf [2];

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dring_queue #(.MAX_DEPTH(MAXD), .SW_PRODUCER(1'b1)) u_dring_queue (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata[0]), .hw_adv(hw_adv),
        .hw_adv_ok(ok[0]), .hw_entry_addr(entry[0]), .q_level(lvl[0]),
        .q_empty(emp[0]), .q_full(ful[0]), .q_al_empty(ale[0]), .q_al_full(alf[0])
    );

    dring_queue #(.MAX_DEPTH(MAXD), .SW_PRODUCER(1'b0)) u_dring_queue_cmpl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata[1]), .hw_adv(hw_adv),
        .hw_adv_ok(ok[1]), .hw_entry_addr(entry[1]), .q_level(lvl[1]),
        .q_empty(emp[1]), .q_full(ful[1]), .q_al_empty(ale[1]), .q_al_full(alf[1])
    );

    // Behavioural model state, index 0 = fill ring, 1 = completion ring
    logic [31:0] m_base [2];
    int m_depth [2];
    int m_wr [2];
    int m_rd [2];
    int m_en [2];
    int m_lo [2];
    int m_hi [2];

    function automatic int used_of(int k);
        return (m_wr[k] - m_rd[k] + m_depth[k]) % m_depth[k];
    endfunction

    function automatic int level_of(int k);
        return (k == 0) ? used_of(k) : (m_depth[k] - 1 - used_of(k));
    endfunction

    function automatic bit blocked_of(int k);
        return (k == 0) ? (used_of(k) == 0) : (used_of(k) == m_depth[k] - 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_base[k] = '0; m_depth[k] = MAXD; m_wr[k] = 0; m_rd[k] = 0;
            m_en[k] = 0; m_lo[k] = 0; m_hi[k] = MAXD - 1;
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < 2; k++) begin
            int hwp;
            logic [31:0] exp_rd;
            string rtag;
            hwp = (k == 0) ? m_rd[k] : m_wr[k];
            chk("R7 hw_adv_ok", 32'(ok[k]), 32'(hw_adv && !blocked_of(k)));
            chk("R6 hw_entry_addr", entry[k], m_base[k] + 32'(hwp * 32));
            chk("R8 q_level", 32'(lvl[k]), 32'(level_of(k)));
            chk("R9 q_empty", 32'(emp[k]), 32'(used_of(k) == 0));
            chk("R9 q_full", 32'(ful[k]), 32'(used_of(k) == m_depth[k] - 1));
            chk("R10 q_al_empty", 32'(ale[k]), 32'(level_of(k) <= m_lo[k]));
            chk("R10 q_al_full", 32'(alf[k]), 32'(level_of(k) >= m_hi[k]));
            case (reg_addr[4:2])
                3'd0: begin exp_rd = 32'(m_en[k]);        rtag = "R1 enable word"; end
                3'd1: begin exp_rd = m_base[k];           rtag = "R2 base"; end
                3'd2: begin exp_rd = 32'(m_depth[k] * 8); rtag = "R3 depth"; end
                3'd3: begin exp_rd = 32'(m_wr[k] * 32);   rtag = (k == 0) ? "R4 sw wptr" : "R5 hw wptr"; end
                3'd4: begin exp_rd = 32'(m_rd[k] * 32);   rtag = (k == 0) ? "R5 hw rptr" : "R4 sw rptr"; end
                3'd5: begin exp_rd = 32'(level_of(k));    rtag = "R8 level word"; end
                3'd6: begin exp_rd = 32'(m_lo[k]);        rtag = "R10 low threshold"; end
                default: begin exp_rd = 32'(m_hi[k]);     rtag = "R10 high threshold"; end
            endcase
            chk(rtag, rdata[k], exp_rd);
        end
    endtask

    task automatic model_step();
        for (int k = 0; k < 2; k++) begin
            bit acc, resize, preset;
            int sel, cand, idx, swsel, hwsel;
            acc = hw_adv && !blocked_of(k);
            resize = 0; preset = 0;
            sel = int'(reg_addr[4:2]);
            swsel = (k == 0) ? 3 : 4;
            hwsel = (k == 0) ? 4 : 3;
            idx = int'((reg_wdata >> 5) & 32'(m_depth[k] - 1));
            if (reg_wr) begin
                if (sel == 0) m_en[k] = int'(reg_wdata[2:0]);
                else if (sel == 1) begin
                    if (m_en[k][2]) m_base[k] = reg_wdata;
                end else if (sel == 2) begin
                    cand = int'(reg_wdata >> 3);
                    if (m_en[k][1] && (reg_wdata >> 3) < 32'd2048 && cand >= 2
                        && cand <= MAXD && (cand & (cand - 1)) == 0) begin
                        m_depth[k] = cand; m_wr[k] = 0; m_rd[k] = 0; resize = 1;
                    end
                end else if (sel == 6) m_lo[k] = int'(reg_wdata[DW-1:0]);
                else if (sel == 7) m_hi[k] = int'(reg_wdata[DW-1:0]);
                else if (sel == swsel) begin
                    if (k == 0) m_wr[k] = idx; else m_rd[k] = idx;
                end else if (sel == hwsel && m_en[k][0]) begin
                    preset = 1;
                    if (k == 0) m_rd[k] = idx; else m_wr[k] = idx;
                end
            end
            if (acc && !resize && !preset) begin
                if (k == 0) m_rd[k] = (m_rd[k] + 1) % m_depth[k];
                else        m_wr[k] = (m_wr[k] + 1) % m_depth[k];
            end
        end
    endtask

    task automatic cycle();
        #1;
        compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic wr_reg(input int word, input logic [31:0] val, input bit adv);
        reg_wr = 1'b1; reg_addr = 5'(word * 4); reg_wdata = val; hw_adv = adv;
        cycle();
        reg_wr = 1'b0; hw_adv = 1'b0;
    endtask

    task automatic idle(input int word, input bit adv);
        reg_wr = 1'b0; reg_addr = 5'(word * 4); hw_adv = adv;
        cycle();
        hw_adv = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every word
        for (int w = 0; w < 8; w++) idle(w, 1'b0);

        // R2: base ignored while disabled, then accepted
        wr_reg(1, 32'h1000_0040, 1'b0);
        idle(1, 1'b0);
        wr_reg(0, 32'h4, 1'b0);
        wr_reg(1, 32'h1000_0040, 1'b0);
        idle(1, 1'b0);

        // R3: depth ignored while disabled, illegal depth ignored, legal accepted
        wr_reg(2, 32'(8 << 3), 1'b0);
        idle(2, 1'b0);
        wr_reg(0, 32'h2, 1'b0);
        wr_reg(2, 32'(6 << 3), 1'b0);
        idle(2, 1'b0);
        wr_reg(2, 32'(8 << 3), 1'b0);
        idle(2, 1'b0);

        // R10: thresholds
        wr_reg(6, 32'd2, 1'b0);
        wr_reg(7, 32'd5, 1'b0);

        // R5/R4: preset engine pointer on the completion ring, sw posts on fill
        wr_reg(0, 32'h1, 1'b0);
        wr_reg(3, 32'(5 * 32), 1'b0);
        idle(5, 1'b0);

        // R6/R7: drain fill ring, fill completion ring, into blocking
        for (int i = 0; i < 8; i++) idle(4, 1'b1);
        idle(3, 1'b1);

        // R5: engine pointer write ignored while bit 0 clear
        wr_reg(0, 32'h0, 1'b0);
        wr_reg(4, 32'(2 * 32), 1'b0);
        idle(4, 1'b0);
        wr_reg(3, 32'(1 * 32), 1'b0);
        idle(3, 1'b0);

        // R8: level word ignores writes
        wr_reg(5, 32'h3, 1'b0);
        idle(5, 1'b0);

        // R11: preset of the engine pointer under a live advance
        wr_reg(0, 32'h1, 1'b0);
        wr_reg(3, 32'(6 * 32), 1'b0);
        wr_reg(4, 32'(3 * 32), 1'b1);
        reg_addr = 5'd16;
        #1;
        chk("R11 preset beats advance (fill)", rdata[0], 32'd96);
        chk("R11 sw write with advance (completion)", rdata[1], 32'd96);

        // R11: random mix of concurrent pointer writes and advances
        for (int i = 0; i < 600; i++) begin
            int op;
            bit adv;
            op = int'($urandom % 10);
            adv = bit'($urandom % 2);
            case (op)
                0, 1, 2: wr_reg(3, 32'(($urandom % 16) * 32 + ($urandom % 32)), adv);
                3, 4:    wr_reg(4, 32'(($urandom % 16) * 32), adv);
                5:       wr_reg(0, 32'($urandom % 8), adv);
                6: begin
                    int dsel;
                    dsel = int'($urandom % 5);
                    wr_reg(2, 32'(((dsel == 0) ? 2 : (dsel == 1) ? 4 : (dsel == 2) ? 8 :
                                   (dsel == 3) ? 6 : 16) << 3), adv);
                end
                default: idle(int'($urandom % 8), adv);
            endcase
        end

        // R1: reset clears everything again
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int w = 0; w < 8; w++) idle(w, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule